// File: doc/BRIEF.md
# Dual-Mode Status and Exception Register

This block holds two 32-bit status words. One belongs to the supervisor and one to the user program. The control logic around them tracks the processor's execution mode and its exception state. The pipeline sends one-cycle event pulses: break, bus error, divide by zero, floating-point error, trap, illegal instruction and interrupt. The block steers each event to the copy that matches the mode in which it occurred.

An event taken in user mode records its cause in the user word and drops the processor into supervisor mode. A fault in supervisor mode records its cause in the supervisor word and raises a halt request for an external debugger. When the supervisor returns to user mode, every cause flag in the user word clears.

Two sources can write either word. Supervisor software writes through one port, and the debugger writes through a second port that takes priority. The block outputs the current mode, the halt request, a wait-for-interrupt indication and a one-cycle instruction-cache clear pulse. It also gives continuous read-back of both words.

Top module: `msr_status_top`

## Requirements
- R1: After reset the block is in supervisor mode (`user_mode`=0), `halt_req`, `sleeping` and `icache_clr` are 0, and both status outputs read zero while `phase_in` is 0.
- R2: Both read-back words always show bit 14 as 0 and bits 31..23 as 0, and bit 13 follows `phase_in`. The other bits show the stored value.
- R3: An accepted write loads bits 22..15 and 12..0 of the selected word (`*_wr_sel` 0 = supervisor word, 1 = user word) and leaves the others unchanged. A debugger write is always accepted and, if both ports write in one cycle, the debugger write wins. A software write is accepted only in supervisor mode while not halted.
- R4: An accepted write with data bit 14 set makes `icache_clr` high for exactly the next cycle.
- R5: `user_mode` equals supervisor bit 5. In user mode, a bus error, divide by zero or floating-point error sets user bit 10, 11 or 12 respectively and clears supervisor bit 5.
- R6: In supervisor mode, a bus error, divide by zero, floating-point error or illegal instruction sets supervisor bit 10, 11, 12 or 8 respectively and raises `halt_req`. These supervisor bits clear only on reset or on a write to the supervisor word.
- R7: A break in user mode raises `halt_req` and leaves the mode unchanged when supervisor bit 7 is 1. When supervisor bit 7 is 0, the break sets user bit 7 and enters supervisor mode. A break in supervisor mode always raises `halt_req`.
- R8: In user mode, a trap sets user bit 9 and an illegal instruction sets user bit 8, and both enter supervisor mode. An interrupt enters supervisor mode without setting any flag. In supervisor mode, trap and interrupt have no effect.
- R9: When supervisor bit 5 goes from 0 to 1 (return to user mode), user bits 12..7 become 0.
- R10: When an event sets a flag in a word that a write targets in the same cycle, the flag ends up set.
- R11: While `halt_req` is 1, events and software writes have no effect. A debugger write to the supervisor word clears `halt_req`.
- R12: `sleeping` is high when supervisor bits 4 and 5 are both 1. Any switch into supervisor mode clears supervisor bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_in | input | 1 | Instruction phase, shown in bit 13 of both words |
| ev_break | input | 1 | Break instruction pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| ev_div_zero | input | 1 | Divide-by-zero pulse |
| ev_fp_err | input | 1 | Floating-point error pulse |
| ev_trap | input | 1 | Trap pulse |
| ev_illegal | input | 1 | Illegal instruction pulse |
| ev_irq | input | 1 | Interrupt pulse |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 1 | Software write target (0 supervisor, 1 user) |
| sw_wr_data | input | 32 | Software write data |
| dbg_wr_en | input | 1 | Debugger write strobe |
| dbg_wr_sel | input | 1 | Debugger write target (0 supervisor, 1 user) |
| dbg_wr_data | input | 32 | Debugger write data |
| user_mode | output | 1 | 1 when running in user mode |
| halt_req | output | 1 | Halt request to the debugger |
| sleeping | output | 1 | Waiting for an interrupt |
| icache_clr | output | 1 | One-cycle instruction-cache clear |
| sup_status | output | 32 | Supervisor word read-back |
| usr_status | output | 32 | User word read-back |

## Verification
The bench builds the block with its default 32-bit layout: reserved writable bits 22..15 and the flags in bits 12..4. It can therefore check every field position that software and the debugger see. Random events and writes on both ports reach the harder corners, such as a break with halting enabled, writes and exceptions that land in the same cycle, and a return to user mode in the middle of traffic. Directed steps cover each mode transition and halt recovery separately.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int DATA_W  = 32;
    localparam int B_CACHE = 14;
    localparam int B_PHASE = 13;
    localparam int B_FPE   = 12;
    localparam int B_DIVZ  = 11;
    localparam int B_BUSE  = 10;
    localparam int B_TRAP  = 9;
    localparam int B_ILL   = 8;
    localparam int B_BRK   = 7;
    localparam int B_GIE   = 5;
    localparam int B_SLEEP = 4;
    localparam int RSV_LO  = 15;
    localparam int RSV_HI  = 22;

    function automatic logic [DATA_W-1:0] mk_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= B_FPE || (i >= RSV_LO && i <= RSV_HI)) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] WR_MASK = mk_mask();

    typedef struct packed {
        logic [DATA_W-1:0] sup;
        logic [DATA_W-1:0] usr;
        logic              halt;
        logic              clr;
    } msr_state_t;

    typedef struct packed {
        logic              sup_en;
        logic              usr_en;
        logic              dbg_sup;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] view(input logic [DATA_W-1:0] r, input logic ph);
        logic [DATA_W-1:0] v;
        v = r & WR_MASK;
        v[B_PHASE] = ph;
        return v;
    endfunction
endpackage

// File: rtl/msr_wr_port.sv
module msr_wr_port
    import msr_pkg::*;
(
    input  logic              sw_en,
    input  logic              sw_sel,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              dbg_en,
    input  logic              dbg_sel,
    input  logic [DATA_W-1:0] dbg_data,
    input  logic              in_user,
    input  logic              halted,
    output wr_req_t           req
);
    always_comb begin
        req = '0;
        if (dbg_en) begin
            req.sup_en  = !dbg_sel;
            req.usr_en  = dbg_sel;
            req.dbg_sup = !dbg_sel;
            req.data    = dbg_data;
        end else if (sw_en && !in_user && !halted) begin
            req.sup_en = !sw_sel;
            req.usr_en = sw_sel;
            req.data   = sw_data;
        end
    end
endmodule

// File: rtl/msr_evt_route.sv
module msr_evt_route
    import msr_pkg::*;
(
    input  logic              in_user,
    input  logic              halted,
    input  logic              brk_en,
    input  logic              ev_break,
    input  logic              ev_bus_err,
    input  logic              ev_div_zero,
    input  logic              ev_fp_err,
    input  logic              ev_trap,
    input  logic              ev_illegal,
    input  logic              ev_irq,
    output logic [DATA_W-1:0] usr_set,
    output logic [DATA_W-1:0] sup_set,
    output logic              to_super,
    output logic              halt_set
);
    logic [DATA_W-1:0] fault_bits;

    always_comb begin
        fault_bits          = '0;
        fault_bits[B_BUSE]  = ev_bus_err;
        fault_bits[B_DIVZ]  = ev_div_zero;
        fault_bits[B_FPE]   = ev_fp_err;
        fault_bits[B_ILL]   = ev_illegal;
        usr_set  = '0;
        sup_set  = '0;
        to_super = 1'b0;
        halt_set = 1'b0;
        if (!halted) begin
            if (in_user) begin
                usr_set         = fault_bits;
                usr_set[B_TRAP] = ev_trap;
                usr_set[B_BRK]  = ev_break && !brk_en;
                halt_set        = ev_break && brk_en;
                to_super        = (|fault_bits) || ev_trap || ev_irq || (ev_break && !brk_en);
            end else begin
                sup_set  = fault_bits;
                halt_set = (|fault_bits) || ev_break;
            end
        end
    end
endmodule

// File: rtl/msr_status_top.sv
module msr_status_top
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_in,
    input  logic              ev_break,
    input  logic              ev_bus_err,
    input  logic              ev_div_zero,
    input  logic              ev_fp_err,
    input  logic              ev_trap,
    input  logic              ev_illegal,
    input  logic              ev_irq,
    input  logic              sw_wr_en,
    input  logic              sw_wr_sel,
    input  logic [DATA_W-1:0] sw_wr_data,
    input  logic              dbg_wr_en,
    input  logic              dbg_wr_sel,
    input  logic [DATA_W-1:0] dbg_wr_data,
    output logic              user_mode,
    output logic              halt_req,
    output logic              sleeping,
    output logic              icache_clr,
    output logic [DATA_W-1:0] sup_status,
    output logic [DATA_W-1:0] usr_status
);
    msr_state_t        st_d, st_q;
    wr_req_t           req;
    logic [DATA_W-1:0] usr_set, sup_set;
    logic              to_super, halt_set;

    msr_wr_port i_wr (
        .sw_en   (sw_wr_en),
        .sw_sel  (sw_wr_sel),
        .sw_data (sw_wr_data),
        .dbg_en  (dbg_wr_en),
        .dbg_sel (dbg_wr_sel),
        .dbg_data(dbg_wr_data),
        .in_user (st_q.sup[B_GIE]),
        .halted  (st_q.halt),
        .req     (req)
    );

    msr_evt_route i_evt (
        .in_user    (st_q.sup[B_GIE]),
        .halted     (st_q.halt),
        .brk_en     (st_q.sup[B_BRK]),
        .ev_break   (ev_break),
        .ev_bus_err (ev_bus_err),
        .ev_div_zero(ev_div_zero),
        .ev_fp_err  (ev_fp_err),
        .ev_trap    (ev_trap),
        .ev_illegal (ev_illegal),
        .ev_irq     (ev_irq),
        .usr_set    (usr_set),
        .sup_set    (sup_set),
        .to_super   (to_super),
        .halt_set   (halt_set)
    );

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (req.sup_en) st_d.sup = (st_q.sup & ~WR_MASK) | (req.data & WR_MASK);
        if (req.usr_en) st_d.usr = (st_q.usr & ~WR_MASK) | (req.data & WR_MASK);
        if (req.sup_en || req.usr_en) st_d.clr = req.data[B_CACHE];
        if (req.dbg_sup) st_d.halt = 1'b0;
        // return to user mode wipes the user cause flags
        if (!st_q.sup[B_GIE] && st_d.sup[B_GIE]) st_d.usr[B_FPE:B_BRK] = '0;
        // event sets are applied last so they win over writes
        st_d.usr = st_d.usr | usr_set;
        st_d.sup = st_d.sup | sup_set;
        if (to_super) begin
            st_d.sup[B_GIE]   = 1'b0;
            st_d.sup[B_SLEEP] = 1'b0;
        end
        if (halt_set) st_d.halt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign user_mode  = st_q.sup[B_GIE];
    assign halt_req   = st_q.halt;
    assign sleeping   = st_q.sup[B_GIE] && st_q.sup[B_SLEEP];
    assign icache_clr = st_q.clr;
    assign sup_status = view(st_q.sup, phase_in);
    assign usr_status = view(st_q.usr, phase_in);
endmodule

// File: rtl/msr_chk.sv
module msr_chk
    import msr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_break,
    input logic              ev_bus_err,
    input logic              ev_div_zero,
    input logic              dbg_wr_en,
    input logic              user_mode,
    input logic              halt_req,
    input logic [DATA_W-1:0] sup_status,
    input logic [DATA_W-1:0] usr_status
);
    always_comb begin
        if (rst_n) begin
            a_r2_cache_bit_zero: assert (!sup_status[B_CACHE] && !usr_status[B_CACHE]);
            a_r2_reserved_zero: assert (sup_status[DATA_W-1:RSV_HI+1] == '0 && usr_status[DATA_W-1:RSV_HI+1] == '0);
        end
    end

    a_r5_user_exc_super: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && !halt_req && ev_bus_err) |=> (!user_mode && usr_status[B_BUSE]));

    a_r6_sup_exc_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && !halt_req && ev_div_zero) |=> (halt_req && sup_status[B_DIVZ]));

    a_r7_sup_break_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && !halt_req && ev_break) |=> halt_req);

    a_r9_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_mode) |-> (usr_status[B_FPE:B_BRK] == '0));

    a_r11_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !dbg_wr_en) |=> ($stable(sup_status[B_FPE:0]) && $stable(usr_status[B_FPE:0]) && halt_req));
endmodule

bind msr_status_top msr_chk i_msr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_break   (ev_break),
    .ev_bus_err (ev_bus_err),
    .ev_div_zero(ev_div_zero),
    .dbg_wr_en  (dbg_wr_en),
    .user_mode  (user_mode),
    .halt_req   (halt_req),
    .sup_status (sup_status),
    .usr_status (usr_status)
);

// File: tb/test_msr_status_top.sv
`timescale 1ns/1ps
module test_msr_status_top;
    localparam int W = 32;
    localparam logic [W-1:0] MASK = 32'h007F_9FFF;

    logic clk = 1'b0;
    logic rst_n;
    logic phase_in;
    logic ev_break, ev_bus_err, ev_div_zero, ev_fp_err, ev_trap, ev_illegal, ev_irq;
    logic sw_wr_en, sw_wr_sel, dbg_wr_en, dbg_wr_sel;
    logic [W-1:0] sw_wr_data, dbg_wr_data;
    logic user_mode, halt_req, sleeping, icache_clr;
    logic [W-1:0] sup_status, usr_status;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_sup, m_usr;
    logic m_halt, m_clr;

    always #2.5 clk = ~clk;

    msr_status_top i_msr_status_top (.*);

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ev_break = 0; ev_bus_err = 0; ev_div_zero = 0; ev_fp_err = 0;
        ev_trap = 0; ev_illegal = 0; ev_irq = 0;
        sw_wr_en = 0; sw_wr_sel = 0; sw_wr_data = '0;
        dbg_wr_en = 0; dbg_wr_sel = 0; dbg_wr_data = '0;
    endtask

    function automatic logic [W-1:0] rd(input logic [W-1:0] r, input logic ph);
        logic [W-1:0] v;
        v = r & MASK;
        v[13] = ph;
        return v;
    endfunction

    // reference model built from the requirements
    task automatic model_step();
        logic um, acc, ws, wu, dsup;
        logic [W-1:0] d, ns, nu, fb;
        logic nh, nc, tos, hs;
        um = m_sup[5];
        ns = m_sup; nu = m_usr; nh = m_halt; nc = 1'b0;
        ws = 0; wu = 0; dsup = 0; d = '0; acc = 0;
        if (dbg_wr_en) begin acc = 1; d = dbg_wr_data; ws = !dbg_wr_sel; wu = dbg_wr_sel; dsup = !dbg_wr_sel; end
        else if (sw_wr_en && !um && !m_halt) begin acc = 1; d = sw_wr_data; ws = !sw_wr_sel; wu = sw_wr_sel; end
        if (ws) ns = (m_sup & ~MASK) | (d & MASK);
        if (wu) nu = (m_usr & ~MASK) | (d & MASK);
        if (acc) nc = d[14];
        if (dsup) nh = 1'b0;
        if (!m_sup[5] && ns[5]) nu[12:7] = '0;
        fb = '0; fb[10] = ev_bus_err; fb[11] = ev_div_zero; fb[12] = ev_fp_err; fb[8] = ev_illegal;
        tos = 0; hs = 0;
        if (!m_halt) begin
            if (um) begin
                nu = nu | fb;
                if (ev_trap) nu[9] = 1'b1;
                if (ev_break && !m_sup[7]) nu[7] = 1'b1;
                hs = ev_break && m_sup[7];
                tos = (|fb) || ev_trap || ev_irq || (ev_break && !m_sup[7]);
            end else begin
                ns = ns | fb;
                hs = (|fb) || ev_break;
            end
        end
        if (tos) begin ns[5] = 1'b0; ns[4] = 1'b0; end
        if (hs) nh = 1'b1;
        m_sup = ns; m_usr = nu; m_halt = nh; m_clr = nc;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        #1;
        clear_inputs();
    endtask

    task automatic sw_write(input logic sel, input logic [W-1:0] d);
        sw_wr_en = 1; sw_wr_sel = sel; sw_wr_data = d;
    endtask

    task automatic dbg_write(input logic sel, input logic [W-1:0] d);
        dbg_wr_en = 1; dbg_wr_sel = sel; dbg_wr_data = d;
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_inputs();
        phase_in = 0;
        rst_n = 0;
        m_sup = '0; m_usr = '0; m_halt = 0; m_clr = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;

        chk("R1 user_mode", {31'b0, user_mode}, 0);
        chk("R1 halt_req", {31'b0, halt_req}, 0);
        chk("R1 sleeping", {31'b0, sleeping}, 0);
        chk("R1 icache_clr", {31'b0, icache_clr}, 0);
        chk("R1 sup_status", sup_status, 0);
        chk("R1 usr_status", usr_status, 0);
        phase_in = 1; #1;
        chk("R2 phase bit", {31'b0, sup_status[13]}, 1);
        phase_in = 0; #1;

        sw_write(1, 32'hFFFF_FFFF); step();
        chk("R3 writable mask", usr_status, 32'h007F_9FFF);
        chk("R4 clear pulse high", {31'b0, icache_clr}, 1);
        step();
        chk("R4 clear pulse ends", {31'b0, icache_clr}, 0);

        sw_write(0, 32'h20); step();
        chk("R9 enter user", {31'b0, user_mode}, 1);
        chk("R9 user flags cleared", usr_status, 32'h007F_807F);

        sw_write(1, 32'h0); step();
        chk("R3 user-mode write ignored", usr_status, 32'h007F_807F);

        ev_bus_err = 1; step();
        chk("R5 bus error flag", {31'b0, usr_status[10]}, 1);
        chk("R5 to supervisor", {31'b0, user_mode}, 0);
        chk("R5 no halt", {31'b0, halt_req}, 0);

        sw_write(0, 32'h20); step();
        chk("R9 bus flag cleared", {31'b0, usr_status[10]}, 0);

        ev_break = 1; step();
        chk("R7 break reason", {31'b0, usr_status[7]}, 1);
        chk("R7 break to supervisor", {31'b0, user_mode}, 0);

        sw_write(0, 32'hA0); step();
        ev_break = 1; step();
        chk("R7 enabled break halts", {31'b0, halt_req}, 1);
        chk("R7 enabled break keeps mode", {31'b0, user_mode}, 1);

        ev_div_zero = 1; step();
        chk("R11 event ignored when halted", {31'b0, usr_status[11]}, 0);
        chk("R11 mode kept when halted", {31'b0, user_mode}, 1);

        dbg_write(0, 32'h0); step();
        chk("R11 debugger clears halt", {31'b0, halt_req}, 0);

        ev_fp_err = 1; step();
        chk("R6 sup fp flag", {31'b0, sup_status[12]}, 1);
        chk("R6 sup fault halts", {31'b0, halt_req}, 1);
        dbg_write(0, 32'h0); step();
        chk("R6 sup flag cleared by write", sup_status, 0);

        ev_break = 1; step();
        chk("R7 sup break halts", {31'b0, halt_req}, 1);
        dbg_write(0, 32'h0); step();

        ev_trap = 1; ev_irq = 1; step();
        chk("R8 sup trap ignored", sup_status, 0);
        chk("R8 sup trap no halt", {31'b0, halt_req}, 0);

        sw_write(0, 32'h20); step();
        dbg_write(1, 32'h0); ev_trap = 1; step();
        chk("R10 set wins over write", usr_status, 32'h0000_0200);
        chk("R8 trap to supervisor", {31'b0, user_mode}, 0);

        sw_write(0, 32'h20); step();
        ev_irq = 1; step();
        chk("R8 irq to supervisor", {31'b0, user_mode}, 0);
        chk("R8 irq sets no flag", usr_status, 0);

        sw_write(0, 32'h30); step();
        chk("R12 sleeping", {31'b0, sleeping}, 1);
        ev_irq = 1; step();
        chk("R12 wake clears sleep", {31'b0, sleeping}, 0);
        chk("R12 sleep bit cleared", {31'b0, sup_status[4]}, 0);

        sw_write(1, 32'h1); dbg_write(1, 32'h2); step();
        chk("R3 debugger write wins", {28'b0, usr_status[3:0]}, 2);

        // random traffic against the reference model
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 4000; n++) begin
            ev_break    = ($urandom % 16) == 0;
            ev_bus_err  = ($urandom % 16) == 0;
            ev_div_zero = ($urandom % 16) == 0;
            ev_fp_err   = ($urandom % 16) == 0;
            ev_trap     = ($urandom % 16) == 0;
            ev_illegal  = ($urandom % 20) == 0;
            ev_irq      = ($urandom % 10) == 0;
            phase_in    = $urandom % 2;
            if (($urandom % 3) == 0) sw_write($urandom % 2, $urandom);
            if (m_halt ? (($urandom % 3) == 0) : (($urandom % 12) == 0))
                dbg_write($urandom % 2, $urandom);
            step();
            chk("R10 model user_mode", {31'b0, user_mode}, {31'b0, m_sup[5]});
            chk("R11 model halt_req", {31'b0, halt_req}, {31'b0, m_halt});
            chk("R12 model sleeping", {31'b0, sleeping}, {31'b0, m_sup[5] & m_sup[4]});
            chk("R4 model icache_clr", {31'b0, icache_clr}, {31'b0, m_clr});
            chk("R6 model sup_status", sup_status, rd(m_sup, phase_in));
            chk("R5 model usr_status", usr_status, rd(m_usr, phase_in));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule